// File: doc/BRIEF.md
# SPI Register Slave with Parity

This block is a serial configuration port for a larger chip. A host sends 16-bit command words over a four-wire SPI link, with the most significant bit first. Each word carries a watchdog bit, an even-parity bit, a bank bit, a three-bit register address and a ten-bit payload. A command is committed only when chip select returns high. Two conditions must hold at that moment: the frame held a whole, nonzero number of 16-bit words, and the last 16 bits received have even parity. A committed payload goes into one of thirteen configuration registers, which drive parallel outputs to the rest of the chip.

While a frame is shifting, the block returns a readback word on its serial output. The previous committed command chose that word, through its bank bit and its payload bits D2..D0. The choice is either a snapshot of the parallel fault input or one of the configuration registers. After the readback word, the serial output replays the serial input 16 clocks late. Several devices can therefore share one chip select and be chained in series.

All logic runs on one system clock. SCLK, CSB and SI are treated as already synchronous to that clock, and their edges are found by comparing each pin with its value one clock earlier. The serial output is brought out as a data bit and an output enable, so the pad ring can build the tri-state driver.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame starts when CSB falls. SI is sampled on each SCLK rising edge while CSB is low, MSB first. Word fields: bit 15 is the watchdog bit, bit 14 is parity, bit 13 is the bank, bits 12..10 are the address, and bits 9..0 are the payload.
- R2: A command is committed only on a CSB rising edge, and only after a number of SCLK rising edges that is a nonzero multiple of 16. Frames of 0, 15 or 17 bits change no register, the readback selector, the status snapshot or the watchdog output.
- R3: The 16 bits of a committed word must hold an even number of ones. A word with odd parity is discarded completely.
- R4: When a frame holds several words, only the last 16 bits received are decoded and committed.
- R5: A committed word writes its payload into configuration register index {bank, address} when that index is 0..12. Indices 13..15 write nothing, but the command still counts as valid. Register k appears on cfg_o[10k+9:10k]. All registers reset to zero.
- R6: The first 16 bits on SO in a frame are {2'b00, sel[3:0], data[9:0]}. sel is {bit 13, bits 2..0} of the last committed word, and is zero after reset. data is the status snapshot when sel is 0, configuration register sel when sel is 1..12, and zero otherwise.
- R7: SO changes only on an SCLK falling edge, or when CSB falls. From the 17th bit on, SO carries the SI bits delayed by exactly 16 SCLK cycles.
- R8: spi_so_oe is low whenever CSB is high, and high while a frame is in progress.
- R9: The status snapshot takes the value of fault_i right after each committed command, and is held otherwise. It resets to zero.
- R10: wd_o equals bit 15 of the last committed word, and is zero after reset.
- R11: rst is synchronous and active high. While it is asserted, every register holds its reset value and SPI activity has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_csb | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock (mode 0) |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out (data bit) |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| fault_i | input | 10 | Parallel fault/status input |
| cfg_o | output | 130 | Thirteen 10-bit configuration registers, packed |
| wd_o | output | 1 | Watchdog bit of the last committed command |

## Verification
A wrong bit counter or a missed parity check shows up at the CSB rising edge that ends the frame: a configuration register changes within two system clocks when it should not, or fails to change. A corrupted readback selector or status snapshot does not appear until the next frame, in its first 16 SO bits. A slip in the shift register shows up in the 17th SO bit of a multi-word frame, or at the far end of a two-device chain. There the downstream device's readback and committed register both come out wrong.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int CMD_W     = 16;
    localparam int PAYLOAD_W = 10;
    localparam int ADDR_W    = 3;
    localparam int SEL_W     = ADDR_W + 1;
    localparam int PAD_W     = CMD_W - SEL_W - PAYLOAD_W;
    localparam int CFG_REGS  = 13;

    typedef struct packed {
        logic                 wd;
        logic                 par;
        logic                 bank;
        logic [ADDR_W-1:0]    addr;
        logic [PAYLOAD_W-1:0] payload;
    } cmd_t;

    function automatic logic [SEL_W-1:0] cmd_reg_index(cmd_t c);
        return {c.bank, c.addr};
    endfunction

    function automatic logic [SEL_W-1:0] cmd_rb_select(cmd_t c);
        return {c.bank, c.payload[ADDR_W-1:0]};
    endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_i,
    input  logic              sclk_i,
    input  logic              si_i,
    input  logic [WORD_W-1:0] load_word_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic              csb_q, sclk_q, active_q, full_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sr_q;
    logic              csb_fall, csb_rise, sclk_rise, sclk_fall, len_ok, par_ok;

    assign csb_fall  = csb_q & ~csb_i;
    assign csb_rise  = ~csb_q & csb_i;
    assign sclk_rise = active_q & ~csb_i & sclk_i & ~sclk_q;
    assign sclk_fall = active_q & ~csb_i & ~sclk_i & sclk_q;
    assign len_ok    = full_q && (cnt_q == '0);
    assign par_ok    = ~(^sr_q);
    assign so_oe_o   = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            csb_q        <= 1'b1;
            sclk_q       <= 1'b0;
            active_q     <= 1'b0;
            full_q       <= 1'b0;
            cnt_q        <= '0;
            sr_q         <= '0;
            so_o         <= 1'b0;
            word_valid_o <= 1'b0;
            word_o       <= '0;
        end else begin
            csb_q        <= csb_i;
            sclk_q       <= sclk_i;
            word_valid_o <= 1'b0;
            if (csb_fall) begin
                active_q <= 1'b1;
                sr_q     <= load_word_i;
                so_o     <= load_word_i[WORD_W-1];
                cnt_q    <= '0;
                full_q   <= 1'b0;
            end else if (csb_rise) begin
                active_q     <= 1'b0;
                word_valid_o <= len_ok && par_ok;
                word_o       <= sr_q;
            end else begin
                if (sclk_rise) begin
                    sr_q  <= {sr_q[WORD_W-2:0], si_i};
                    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) full_q <= 1'b1;
                end
                if (sclk_fall) so_o <= sr_q[WORD_W-1];
            end
        end
    end

    // R8: enable is low whenever chip select was seen high
    p_oe_idle_r8: assert property (@(posedge clk) disable iff (rst)
        csb_q |-> !so_oe_o);
    // R2: a commit pulse only follows a chip-select rising edge
    p_commit_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> $past(csb_rise));
    // R2: the commit is a single-cycle pulse
    p_commit_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);
    // R7: SO moves only on a falling SCLK edge or a frame start
    p_so_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !csb_fall) |=> $stable(so_o));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int NUM_CFG = CFG_REGS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_valid_i,
    input  cmd_t                         cmd_i,
    input  logic [PAYLOAD_W-1:0]         fault_i,
    output logic [NUM_CFG*PAYLOAD_W-1:0] cfg_o,
    output logic                         wd_o,
    output logic [CMD_W-1:0]             rb_word_o
);
    logic [PAYLOAD_W-1:0] cfg_q [NUM_CFG];
    logic [PAYLOAD_W-1:0] status_q;
    logic [SEL_W-1:0]     sel_q;
    logic [PAYLOAD_W-1:0] rb_data;
    logic [SEL_W-1:0]     wr_idx;

    assign wr_idx = cmd_reg_index(cmd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_CFG; k++) cfg_q[k] <= '0;
            status_q <= '0;
            sel_q    <= '0;
            wd_o     <= 1'b0;
        end else if (wr_valid_i) begin
            for (int k = 0; k < NUM_CFG; k++)
                if (wr_idx == SEL_W'(k)) cfg_q[k] <= cmd_i.payload;
            status_q <= fault_i;
            sel_q    <= cmd_rb_select(cmd_i);
            wd_o     <= cmd_i.wd;
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_pack
        assign cfg_o[g*PAYLOAD_W +: PAYLOAD_W] = cfg_q[g];
    end

    always_comb begin
        rb_data = '0;
        if (sel_q == '0) rb_data = status_q;
        for (int k = 1; k < NUM_CFG; k++)
            if (sel_q == SEL_W'(k)) rb_data = cfg_q[k];
    end

    assign rb_word_o = {{PAD_W{1'b0}}, sel_q, rb_data};

    // R2 R3: configuration changes only on a committed command
    p_cfg_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid_i |=> $stable(cfg_o));
    // R6: the readback selector holds between commands
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_valid_i |=> $stable(sel_q));
    // R9: status snapshot taken from the fault input at commit
    p_status_snap_r9: assert property (@(posedge clk) disable iff (rst)
        wr_valid_i |=> status_q == $past(fault_i));
    // R10: watchdog output holds between commands
    p_wd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_valid_i |=> $stable(wd_o));

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NUM_CFG = CFG_REGS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         spi_csb,
    input  logic                         spi_sclk,
    input  logic                         spi_si,
    output logic                         spi_so,
    output logic                         spi_so_oe,
    input  logic [PAYLOAD_W-1:0]         fault_i,
    output logic [NUM_CFG*PAYLOAD_W-1:0] cfg_o,
    output logic                         wd_o
);
    logic [CMD_W-1:0] rb_word;
    logic [CMD_W-1:0] rx_word;
    logic             rx_valid;
    cmd_t             rx_cmd;

    assign rx_cmd = cmd_t'(rx_word);

    spi_frame_shifter #(.WORD_W(CMD_W)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .csb_i        (spi_csb),
        .sclk_i       (spi_sclk),
        .si_i         (spi_si),
        .load_word_i  (rb_word),
        .so_o         (spi_so),
        .so_oe_o      (spi_so_oe),
        .word_valid_o (rx_valid),
        .word_o       (rx_word)
    );

    spi_reg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_valid_i (rx_valid),
        .cmd_i      (rx_cmd),
        .fault_i    (fault_i),
        .cfg_o      (cfg_o),
        .wd_o       (wd_o),
        .rb_word_o  (rb_word)
    );

    // R3: every committed word carries even parity
    p_even_parity_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (^rx_word) == 1'b0);

endmodule

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
    localparam int NREG = 13;
    localparam int PW   = 10;

    typedef struct {
        logic [15:0] w;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csb = 1'b1, sclk = 1'b0, si = 1'b0;
    logic chain_mode = 1'b0;
    logic [PW-1:0] fault_a = 10'h0C3;
    logic [PW-1:0] fault_b = 10'h155;
    logic so_a, oe_a, wd_a, so_b, oe_b, wd_b, csb_b;
    logic [NREG*PW-1:0] cfg_a, cfg_b;

    int checks = 0, failures = 0;
    exp_t        exp_q[$];
    logic [15:0] obs_q[$];

    logic [PW-1:0] m_cfg [NREG];
    logic [PW-1:0] m_status;
    logic [3:0]    m_sel;
    logic          m_wd;

    always #2 clk = ~clk;
    assign csb_b = chain_mode ? csb : 1'b1;

    spi_cfg_slave u_dut (
        .clk(clk), .rst(rst), .spi_csb(csb), .spi_sclk(sclk), .spi_si(si),
        .spi_so(so_a), .spi_so_oe(oe_a), .fault_i(fault_a), .cfg_o(cfg_a), .wd_o(wd_a)
    );
    spi_cfg_slave u_dut_b (
        .clk(clk), .rst(rst), .spi_csb(csb_b), .spi_sclk(sclk), .spi_si(so_a),
        .spi_so(so_b), .spi_so_oe(oe_b), .fault_i(fault_b), .cfg_o(cfg_b), .wd_o(wd_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                       input logic [159:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit wd, input bit bank,
                                       input logic [2:0] a, input logic [9:0] p);
        logic [15:0] w;
        w = {wd, 1'b0, bank, a, p};
        w[14] = ^w;
        return w;
    endfunction

    function automatic logic [NREG*PW-1:0] model_cfg();
        logic [NREG*PW-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*PW +: PW] = m_cfg[k];
        return v;
    endfunction

    function automatic logic [15:0] model_rb();
        logic [9:0] d;
        if (m_sel == 4'd0) d = m_status;
        else if (m_sel < 4'(NREG)) d = m_cfg[m_sel];
        else d = '0;
        return {2'b00, m_sel, d};
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NREG; k++) m_cfg[k] = '0;
        m_status = '0; m_sel = '0; m_wd = 1'b0;
    endtask

    task automatic model_commit(input logic [15:0] w);
        logic [3:0] idx;
        idx = {w[13], w[12:10]};
        if (idx < 4'(NREG)) m_cfg[idx] = w[9:0];
        m_sel = {w[13], w[2:0]};
        m_status = fault_a;
        m_wd = w[15];
    endtask

    // driver: one frame of n bits, MSB first; collects SO chunks for the monitor
    task automatic xfer(input logic [31:0] bits, input int n, input bit from_chain,
                        input bit collect);
        logic [31:0] got = '0;
        @(negedge clk); csb = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            si = bits[n-1-i];
            repeat (2) @(negedge clk);
            got = {got[30:0], from_chain ? so_b : so_a};
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        csb = 1'b1;
        repeat (8) @(negedge clk);
        if (collect)
            for (int k = 0; k < n / 16; k++) obs_q.push_back(got[n-1-16*k -: 16]);
    endtask

    task automatic single(input logic [31:0] bits, input int n, input string tag);
        logic [15:0] last;
        for (int k = 0; k < n / 16; k++) begin
            exp_t e;
            e.tag = tag;
            e.w = (k == 0) ? model_rb() : bits[n-1-16*(k-1) -: 16];
            exp_q.push_back(e);
        end
        xfer(bits, n, 1'b0, 1'b1);
        last = bits[15:0];
        if (n > 0 && n % 16 == 0 && (^last) == 1'b0) model_commit(last);
    endtask

    task automatic push_exp(input logic [15:0] w, input string tag);
        exp_t e;
        e.w = w; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check_a(input string tag);
        chk(cfg_a === model_cfg(), {tag, " cfg"}, 160'(cfg_a), 160'(model_cfg()));
        chk(wd_a === m_wd, {tag, " wd"}, 160'(wd_a), 160'(m_wd));
    endtask

    // monitor: pops observed SO words and compares them with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                logic [15:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected SO word", 160'(o), 160'(0));
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(o === e.w, {e.tag, " SO word"}, 160'(o), 160'(e.w));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 160'(0), 160'(1));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        // R11 reset state, R8 enable low while idle
        check_a("R11 reset");
        chk(oe_a === 1'b0, "R8 idle enable", 160'(oe_a), 160'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R5: bank 0 address 3 write
        single(32'(mk(0, 0, 3'd3, 10'h2A3)), 16, "R1");
        check_a("R5 write idx3");
        // R10: watchdog bit set, bank 1 address 2 -> index 10
        single(32'(mk(1, 1, 3'd2, 10'h155)), 16, "R6");
        check_a("R10 wd set");
        // R3: odd parity is discarded
        single(32'(mk(0, 0, 3'd5, 10'h3FF) ^ 16'h4000), 16, "R6 after idx10");
        check_a("R3 bad parity");
        // R2: 15 and 17 bit frames are discarded
        single(32'(mk(0, 0, 3'd6, 10'h0F0) & 16'h7FFF), 15, "R2");
        check_a("R2 15 bits");
        single({15'd0, 1'b1, mk(0, 0, 3'd6, 10'h0F0)}, 17, "R2 17 bits");
        check_a("R2 17 bits");
        // R4 R7: two words, only the last committed; SI replayed after 16 bits
        single({mk(0, 0, 3'd1, 10'h111), mk(0, 1, 3'd4, 10'h0AA)}, 32, "R7");
        check_a("R4 last word");
        // R5: index 14 writes nothing but moves the selector
        single(32'(mk(0, 1, 3'd6, 10'h3C5)), 16, "R6");
        check_a("R5 unmapped index");
        // R9: status snapshot selected
        fault_a = 10'h2E7;
        single(32'(mk(0, 0, 3'd0, 10'h000)), 16, "R6 sel13");
        fault_a = 10'h018;
        single(32'(mk(0, 0, 3'd2, 10'h001) ^ 16'h4000), 16, "R9 status");
        single(32'(mk(0, 0, 3'd7, 10'h003)), 16, "R9 status held");
        // R6: readback of a configuration register
        single(32'(mk(0, 0, 3'd5, 10'h000)), 16, "R6 cfg3");
        check_a("R6 sequence");

        // R8 R2: zero-bit frame, enable high while selected
        @(negedge clk); csb = 1'b0;
        repeat (6) @(negedge clk);
        chk(oe_a === 1'b1, "R8 active enable", 160'(oe_a), 160'(1));
        csb = 1'b1;
        repeat (8) @(negedge clk);
        chk(oe_a === 1'b0, "R8 enable after frame", 160'(oe_a), 160'(0));
        check_a("R2 zero bits");

        // R11: frame during reset has no effect
        rst = 1'b1;
        xfer(32'(mk(0, 0, 3'd2, 10'h1FF)), 16, 1'b0, 1'b0);
        rst = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_a("R11 ignored frame");

        // R7: two-device chain
        chain_mode = 1'b1;
        push_exp(16'h0000, "R7 chain far readback");
        push_exp(model_rb(), "R7 chain near readback");
        xfer({mk(1, 0, 3'd4, 10'h07C), mk(0, 0, 3'd6, 10'h101)}, 32, 1'b1, 1'b1);
        model_commit(mk(0, 0, 3'd6, 10'h101));
        check_a("R7 chain near");
        chk(cfg_b[4*PW +: PW] === 10'h07C, "R7 chain far cfg", 160'(cfg_b[4*PW +: PW]), 160'(10'h07C));
        chk(wd_b === 1'b1, "R7 chain far wd", 160'(wd_b), 160'(1));
        push_exp(16'h107C, "R7 chain far readback 2");
        push_exp(model_rb(), "R7 chain near readback 2");
        xfer({mk(0, 0, 3'd1, 10'h000), mk(0, 0, 3'd2, 10'h2C0)}, 32, 1'b1, 1'b1);
        model_commit(mk(0, 0, 3'd2, 10'h2C0));
        check_a("R7 chain near 2");
        chain_mode = 1'b0;

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", 160'(exp_q.size()), 160'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule